// File: doc/BRIEF.md
# Posted Write Buffer with Burst Grouping

This block sits between a processor's write port and the write port of external memory. A posted write is captured in one cycle, so the processor moves on while the buffer completes the memory write later. Storage has two separate resources. One is a shared pool of eight data words. The other is two address entries. A run of sequential words shares one address entry and takes as many pool words as it has words.

Each write is either posted or forced through unbuffered. A global post-enable input and a per-access bufferable flag make that decision. The write phase of a locked read-modify-write is always unbuffered. An unbuffered write holds the processor until every posted word has reached memory and the unbuffered word itself has been acknowledged. The memory side uses a single request/acknowledge handshake. Posted words leave in arrival order. Within an entry, the word address advances by one for each word.

Top module: `wpb_top`

## Requirements
- R1: The block holds up to eight posted data words shared freely between two address entries. A one-word write followed by a seven-word sequential run is accepted with no stall while memory gives no acknowledge.
- R2: A write is posted (accepted in its first cycle) only when `cfg_post_en`=1, `cpu_wr_bufable`=1 and `cpu_wr_locked`=0. Any other write is unbuffered, and `cpu_stall` is high in its first cycle.
- R3: While `rst_n` is low, and right after reset, `buf_empty`=1, `mem_req`=0 and `cpu_stall`=0. Words posted before reset are discarded and never appear on the memory port.
- R4: A posted write with `cpu_wr_seq`=0 takes a new address entry and one pool word. A posted write with `cpu_wr_seq`=1 that directly follows a posted write joins that write's entry and takes only one pool word.
- R5: A posted write stalls while the pool holds eight words, or while it needs a new address entry and both entries are in use. It is accepted once the oldest entry has fully drained.
- R6: An unbuffered write is issued on the memory port only when the buffer is empty. `cpu_stall` stays high until its own acknowledge has arrived, so no write is outstanding when it is accepted.
- R7: A write with `cpu_wr_locked`=1 is handled as unbuffered even when `cpu_wr_bufable`=1.
- R8: Memory writes occur in the order in which the processor presented them, and each carries the data presented with its address.
- R9: `mem_req`, `mem_addr` and `mem_data` hold steady until `mem_ack`. Successive words of one entry go out at word addresses that increase by one.
- R10: `buf_empty` is 1 exactly when no posted word is waiting or in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_post_en | input | 1 | Global enable for posting writes |
| cpu_wr_valid | input | 1 | Processor write request, held until not stalled |
| cpu_wr_addr | input | AW | Word address of the write |
| cpu_wr_data | input | DW | Write data |
| cpu_wr_seq | input | 1 | Word continues the previous sequential run |
| cpu_wr_bufable | input | 1 | Access target allows posting |
| cpu_wr_locked | input | 1 | Write phase of a locked read-modify-write |
| cpu_stall | output | 1 | Processor must hold the current write |
| mem_req | output | 1 | Memory write request |
| mem_addr | output | AW | Memory write word address |
| mem_data | output | DW | Memory write data |
| mem_ack | input | 1 | Memory has completed the current word |
| buf_empty | output | 1 | No posted word pending |

## Verification
The bench holds back acknowledges so it can fill the buffer exactly to its limits. It checks that a single write plus a seven-word run fits, and that the eighth run word stalls. A design that counted addresses and words as one resource would stall too early. A design that skipped the pool check would overwrite data. A third address must stall while a sequential word joining an open entry must not, which catches burst grouping done wrong. Unbuffered and locked writes are issued behind pending posted words, and the buffer must be fully drained when they are accepted. Posting them would break the write order, and a late stall release would leave words in flight. A mid-traffic reset has to discard held words, and random acknowledge latency with final memory comparison exposes ordering or address-increment errors.

// File: rtl/wpb_pkg.sv
package wpb_pkg;

  typedef enum logic [1:0] {UB_IDLE, UB_ISSUE, UB_DONE} ub_state_e;

  // A write may be posted only when globally enabled, marked bufferable and not locked.
  function automatic logic may_post(logic en, logic bufable, logic locked);
    return en & bufable & ~locked;
  endfunction

  function automatic int unsigned ring_next(int unsigned idx, int unsigned size);
    return (idx + 1 >= size) ? 0 : idx + 1;
  endfunction

  function automatic int unsigned ring_prev(int unsigned idx, int unsigned size);
    return (idx == 0) ? size - 1 : idx - 1;
  endfunction

endpackage

// File: rtl/wpb_data_pool.sv
module wpb_data_pool
  import wpb_pkg::*;
#(
  parameter int DW    = 32,
  parameter int DEPTH = 8,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic [DW-1:0] push_data_i,
  input  logic          pop_i,
  output logic [DW-1:0] head_data_o,
  output logic [CW-1:0] count_o
);

  logic [DW-1:0] slot_q [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (push_i) slot_q[wr_q] <= push_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= PW'(ring_next(32'(wr_q), DEPTH));
      if (pop_i)  rd_q <= PW'(ring_next(32'(rd_q), DEPTH));
      unique case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign head_data_o = slot_q[rd_q];
  assign count_o     = cnt_q;

endmodule

// File: rtl/wpb_addr_ring.sv
module wpb_addr_ring
  import wpb_pkg::*;
#(
  parameter int AW   = 16,
  parameter int AENT = 2,
  parameter int RW   = 4,
  localparam int PW  = (AENT > 1) ? $clog2(AENT) : 1,
  localparam int CW  = $clog2(AENT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_i,
  input  logic [AW-1:0] alloc_addr_i,
  input  logic          extend_i,
  input  logic          advance_i,
  output logic [AW-1:0] head_addr_o,
  output logic [RW-1:0] head_left_o,
  output logic          head_free_o,
  output logic [CW-1:0] count_o
);

  logic [AW-1:0] addr_q [AENT];
  logic [RW-1:0] left_q [AENT];
  logic [PW-1:0] wr_q, rd_q, tail_idx;
  logic [CW-1:0] cnt_q;
  logic          head_free;

  assign tail_idx  = PW'(ring_prev(32'(wr_q), AENT));
  assign head_free = advance_i && (left_q[rd_q] == RW'(1));

  for (genvar e = 0; e < AENT; e++) begin : g_entry
    logic ext_hit, adv_hit, new_hit;
    assign new_hit = alloc_i && (wr_q == PW'(e));
    assign ext_hit = extend_i && (tail_idx == PW'(e));
    assign adv_hit = advance_i && (rd_q == PW'(e));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        addr_q[e] <= '0;
        left_q[e] <= '0;
      end else if (new_hit) begin
        addr_q[e] <= alloc_addr_i;
        left_q[e] <= RW'(1);
      end else begin
        if (adv_hit) addr_q[e] <= addr_q[e] + AW'(1);
        unique case ({ext_hit, adv_hit})
          2'b10:   left_q[e] <= left_q[e] + RW'(1);
          2'b01:   left_q[e] <= left_q[e] - RW'(1);
          default: left_q[e] <= left_q[e];
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (alloc_i)   wr_q <= PW'(ring_next(32'(wr_q), AENT));
      if (head_free) rd_q <= PW'(ring_next(32'(rd_q), AENT));
      unique case ({alloc_i, head_free})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign head_addr_o = addr_q[rd_q];
  assign head_left_o = left_q[rd_q];
  assign head_free_o = head_free;
  assign count_o     = cnt_q;

endmodule

// File: rtl/wpb_top.sv
module wpb_top
  import wpb_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int DEPTH = 8,
  parameter int AENT  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_post_en,
  input  logic          cpu_wr_valid,
  input  logic [AW-1:0] cpu_wr_addr,
  input  logic [DW-1:0] cpu_wr_data,
  input  logic          cpu_wr_seq,
  input  logic          cpu_wr_bufable,
  input  logic          cpu_wr_locked,
  output logic          cpu_stall,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_data,
  input  logic          mem_ack,
  output logic          buf_empty
);

  localparam int DCW = $clog2(DEPTH + 1);
  localparam int ACW = $clog2(AENT + 1);

  // Named internal events, visible to the bound checker.
  logic [DCW-1:0] d_count;
  logic [ACW-1:0] a_count;
  logic [AW-1:0]  head_addr;
  logic [DCW-1:0] head_left;
  logic [DW-1:0]  pool_data;
  logic           head_free;
  logic           is_post, drain_on, drain_ack, can_append;
  logic           data_room, addr_room, post_stall, post_acc;
  logic           ext_go, alloc_go, ub_start;

  ub_state_e      ub_q;
  logic [AW-1:0]  ub_addr_q;
  logic [DW-1:0]  ub_data_q;
  logic           open_q;

  assign is_post    = may_post(cfg_post_en, cpu_wr_bufable, cpu_wr_locked);
  assign drain_on   = (a_count != '0) && (ub_q == UB_IDLE);
  assign drain_ack  = drain_on && mem_ack;
  // Join the open entry unless that entry retires in this very cycle.
  assign can_append = open_q && cpu_wr_seq && (a_count != '0)
                      && !(head_free && (a_count == ACW'(1)));
  assign data_room  = d_count < DCW'(DEPTH);
  assign addr_room  = a_count < ACW'(AENT);
  assign post_stall = !data_room || !(can_append || addr_room);
  assign post_acc   = cpu_wr_valid && is_post && !post_stall;
  assign ext_go     = post_acc && can_append;
  assign alloc_go   = post_acc && !can_append;
  assign ub_start   = cpu_wr_valid && !is_post && (ub_q == UB_IDLE) && buf_empty;

  wpb_data_pool #(.DW(DW), .DEPTH(DEPTH)) i_pool (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_i      (post_acc),
    .push_data_i (cpu_wr_data),
    .pop_i       (drain_ack),
    .head_data_o (pool_data),
    .count_o     (d_count)
  );

  wpb_addr_ring #(.AW(AW), .AENT(AENT), .RW(DCW)) i_ring (
    .clk          (clk),
    .rst_n        (rst_n),
    .alloc_i      (alloc_go),
    .alloc_addr_i (cpu_wr_addr),
    .extend_i     (ext_go),
    .advance_i    (drain_ack),
    .head_addr_o  (head_addr),
    .head_left_o  (head_left),
    .head_free_o  (head_free),
    .count_o      (a_count)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ub_q      <= UB_IDLE;
      ub_addr_q <= '0;
      ub_data_q <= '0;
      open_q    <= 1'b0;
    end else begin
      unique case (ub_q)
        UB_IDLE:  if (ub_start) begin
                    ub_q      <= UB_ISSUE;
                    ub_addr_q <= cpu_wr_addr;
                    ub_data_q <= cpu_wr_data;
                  end
        UB_ISSUE: if (mem_ack) ub_q <= UB_DONE;
        default:  ub_q <= UB_IDLE;
      endcase
      if (post_acc)              open_q <= 1'b1;
      else if (ub_q == UB_DONE)  open_q <= 1'b0;
    end
  end

  assign cpu_stall = cpu_wr_valid && (is_post ? post_stall : (ub_q != UB_DONE));
  assign mem_req   = drain_on || (ub_q == UB_ISSUE);
  assign mem_addr  = (ub_q == UB_ISSUE) ? ub_addr_q : head_addr;
  assign mem_data  = (ub_q == UB_ISSUE) ? ub_data_q : pool_data;
  assign buf_empty = (a_count == '0) && (d_count == '0);

endmodule

// File: rtl/wpb_checker.sv
module wpb_checker #(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int DEPTH = 8,
  parameter int AENT  = 2,
  localparam int DCW  = $clog2(DEPTH + 1),
  localparam int ACW  = $clog2(AENT + 1)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           cfg_post_en,
  input logic           cpu_wr_valid,
  input logic           cpu_wr_seq,
  input logic           cpu_wr_bufable,
  input logic           cpu_wr_locked,
  input logic           cpu_stall,
  input logic           mem_req,
  input logic [AW-1:0]  mem_addr,
  input logic [DW-1:0]  mem_data,
  input logic           mem_ack,
  input logic           buf_empty,
  input logic [DCW-1:0] d_count,
  input logic [ACW-1:0] a_count
);

  logic wants_post;
  assign wants_post = cfg_post_en && cpu_wr_bufable && !cpu_wr_locked;

  AST_POOL_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wr_valid && wants_post && (d_count == DCW'(DEPTH)) |-> cpu_stall); // R5

  AST_ADDR_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wr_valid && wants_post && !cpu_wr_seq && (a_count == ACW'(AENT)) |-> cpu_stall); // R5

  AST_UNBUF_AFTER_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wr_valid && !wants_post && !cpu_stall |-> buf_empty && !mem_req); // R6

  AST_LOCKED_UNBUF: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wr_valid && cpu_wr_locked && !cpu_stall |-> buf_empty); // R7

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_data)); // R9

  AST_EMPTY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    buf_empty |-> (d_count == '0) && (a_count == '0)); // R10

endmodule

bind wpb_top wpb_checker #(.AW(AW), .DW(DW), .DEPTH(DEPTH), .AENT(AENT)) i_wpb_checker (.*);

// File: tb/test_wpb_top.sv
module test_wpb_top;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_post_en = 1'b0;
  logic          cpu_wr_valid = 1'b0;
  logic [AW-1:0] cpu_wr_addr = '0;
  logic [DW-1:0] cpu_wr_data = '0;
  logic          cpu_wr_seq = 1'b0;
  logic          cpu_wr_bufable = 1'b0;
  logic          cpu_wr_locked = 1'b0;
  logic          cpu_stall, mem_req, mem_ack, buf_empty;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_data;

  int n_checks = 0;
  int n_fail   = 0;
  bit hold_ack = 1'b0;
  int wait_cnt = 0;
  logic [AW+DW-1:0] exp_q [$];
  logic [DW-1:0] ref_mem [256];
  logic [DW-1:0] model_mem [256];

  always #(CLK_PERIOD/2) clk = ~clk;

  wpb_top #(.AW(AW), .DW(DW), .DEPTH(8), .AENT(2)) i_wpb_top (.*);

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Memory model and monitor: random latency, compares each write with the queue head.
  initial mem_ack = 1'b0;
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ack  = 1'b0;
      wait_cnt = 0;
    end else if (mem_ack) begin
      mem_ack = 1'b0;
    end else if (mem_req && !hold_ack) begin
      if (wait_cnt == 0) begin
        mem_ack = 1'b1;
        wait_cnt = $urandom_range(0, 3);
        if (exp_q.size() == 0) begin
          check(1'b0, "R8", "unexpected memory write", longint'(mem_addr), 0);
        end else begin
          logic [AW+DW-1:0] e;
          e = exp_q.pop_front();
          check(mem_addr == e[AW+DW-1:DW], "R9", "write address", longint'(mem_addr),
                longint'(e[AW+DW-1:DW]));
          check(mem_data == e[DW-1:0], "R8", "write data in order", longint'(mem_data),
                longint'(e[DW-1:0]));
        end
        model_mem[mem_addr[7:0]] = mem_data;
      end else begin
        wait_cnt--;
      end
    end
  end

  // Driver: posts the expected item, optionally checks the first-cycle stall.
  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic s,
                    input logic b, input logic l, input bit chk, input logic exp_st,
                    input string tag);
    @(negedge clk);
    cpu_wr_valid   = 1'b1;
    cpu_wr_addr    = a;
    cpu_wr_data    = d;
    cpu_wr_seq     = s;
    cpu_wr_bufable = b;
    cpu_wr_locked  = l;
    exp_q.push_back({a, d});
    ref_mem[a[7:0]] = d;
    #1;
    if (chk) begin
      check(cpu_stall == exp_st, tag, "stall on presentation", longint'(cpu_stall),
            longint'(exp_st));
      if (exp_st) hold_ack = 1'b0;
    end
    while (cpu_stall) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1;
    cpu_wr_valid = 1'b0;
  endtask

  task automatic drain_all();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    #1;
    check(buf_empty == 1'b1, "R10", "empty after drain", longint'(buf_empty), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R8 watchdog: cycles=%0d expected < %0d", 150000, 150000);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [AW-1:0] prev_a;
    bit prev_post;
    for (int i = 0; i < 256; i++) begin ref_mem[i] = '0; model_mem[i] = '0; end
    repeat (3) @(negedge clk);
    #1;
    check(buf_empty == 1'b1, "R3", "empty in reset", longint'(buf_empty), 1);
    check(mem_req == 1'b0, "R3", "no request in reset", longint'(mem_req), 0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check(cpu_stall == 1'b0, "R3", "no stall after reset", longint'(cpu_stall), 0);
    cfg_post_en = 1'b1;

    // R2: posted vs. disabled
    wr(16'h10, 32'hA0000010, 0, 1, 0, 1, 1'b0, "R2");
    drain_all();
    cfg_post_en = 1'b0;
    wr(16'h11, 32'hA0000011, 0, 1, 0, 1, 1'b1, "R2");
    check(exp_q.size() == 0, "R6", "unbuffered completed on accept", exp_q.size(), 0);
    cfg_post_en = 1'b1;

    // R1: single + seven-word run with no acknowledges
    hold_ack = 1'b1;
    wr(16'h20, 32'hB0000020, 0, 1, 0, 1, 1'b0, "R1");
    for (int k = 0; k < 7; k++)
      wr(16'h40 + AW'(k), 32'hC0000040 + k, k != 0, 1, 0, 1, 1'b0, "R1");
    @(negedge clk); #1;
    check(buf_empty == 1'b0, "R10", "not empty while holding", longint'(buf_empty), 0);
    wr(16'h47, 32'hC0000047, 1, 1, 0, 1, 1'b1, "R5");
    drain_all();

    // R4 / R5: run word joins open entry, third address stalls
    hold_ack = 1'b1;
    wr(16'h50, 32'hD0000050, 0, 1, 0, 1, 1'b0, "R4");
    wr(16'h60, 32'hD0000060, 0, 1, 0, 1, 1'b0, "R4");
    wr(16'h61, 32'hD0000061, 1, 1, 0, 1, 1'b0, "R4");
    wr(16'h70, 32'hD0000070, 0, 1, 0, 1, 1'b1, "R5");
    drain_all();

    // R6: unbuffered behind posted words
    hold_ack = 1'b1;
    wr(16'h80, 32'hE0000080, 0, 1, 0, 1, 1'b0, "R2");
    wr(16'h81, 32'hE0000081, 1, 1, 0, 0, 1'b0, "R4");
    wr(16'h90, 32'hE0000090, 0, 0, 0, 1, 1'b1, "R6");
    check(exp_q.size() == 0, "R6", "all drained at accept", exp_q.size(), 0);

    // R7: locked bufferable write is unbuffered
    hold_ack = 1'b1;
    wr(16'h98, 32'hF0000098, 0, 1, 0, 0, 1'b0, "R7");
    wr(16'h9A, 32'hF000009A, 0, 1, 1, 1, 1'b1, "R7");
    check(exp_q.size() == 0, "R7", "locked write waited for drain", exp_q.size(), 0);

    // R3: reset discards held words
    hold_ack = 1'b1;
    wr(16'hA0, 32'h1, 0, 1, 0, 0, 1'b0, "R3");
    wr(16'hA1, 32'h2, 1, 1, 0, 0, 1'b0, "R3");
    @(negedge clk);
    rst_n = 1'b0;
    exp_q.delete();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(buf_empty == 1'b1, "R3", "empty after reset", longint'(buf_empty), 1);
    hold_ack = 1'b0;
    repeat (5) @(negedge clk);
    #1;
    check(mem_req == 1'b0, "R3", "discarded words not issued", longint'(mem_req), 0);
    for (int i = 0; i < 256; i++) begin ref_mem[i] = '0; model_mem[i] = '0; end

    // Random traffic with random acknowledge latency
    prev_a = '0;
    prev_post = 1'b0;
    for (int n = 0; n < 300; n++) begin
      logic [AW-1:0] a;
      logic s, b, l, en;
      en = ($urandom_range(0, 9) != 0);
      b  = ($urandom_range(0, 4) != 0);
      l  = ($urandom_range(0, 19) == 0);
      s  = prev_post && (prev_a < 16'hFF) && ($urandom_range(0, 9) < 6);
      a  = s ? prev_a + AW'(1) : AW'($urandom_range(0, 255));
      cfg_post_en = en;
      wr(a, $urandom, s, b, l, 0, 1'b0, "R8");
      if (!(en && b && !l))
        check(exp_q.size() == 0, "R6", "random unbuffered drained", exp_q.size(), 0);
      prev_a = a;
      prev_post = en && b && !l;
    end
    drain_all();
    for (int i = 0; i < 256; i++)
      check(model_mem[i] == ref_mem[i], "R8", "final memory word", longint'(model_mem[i]),
            longint'(ref_mem[i]));

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule